// File: doc/BRIEF.md
# Overridable GPIO Port

An 8-bit general-purpose I/O port built from identical pin cells. A CPU-side bus writes a direction register and an output register, and reads back either register or the synchronized pad level through a small read selector. The pad controls come from these registers by default: output-driver enable, driven value and pull-up enable.

An attached peripheral can take over any pad control pin by pin. Each pin has four override pairs, each an enable and a value. They cover the pull-up, the driver enable, the driven value and the digital-input enable. The peripheral also receives the gated pad input ahead of the synchronizer, so it can apply its own synchronization or use the pin as a clock. A global pull-up kill and a sleep signal are shared by every pin.

Top module: `gpio_port_mux`

## Requirements
- R1: While rst_ni is low, both registers hold 0 and the synchronizer holds 0. With every override enable at 0 this gives pad_oe_o = 0, pad_pu_o = 0, and 0 from every read selection.
- R2: A high dir_we_i loads wdata_i into the direction register at the rising clock edge, and a high out_we_i loads it into the output register; both may load in the same cycle. rdata_o is combinational on rd_sel_i: 0 gives the direction register, 1 the output register, 2 the synchronized pin level, 3 gives all zeros.
- R3: With pu_ovr_en_i[n] low, pad_pu_o[n] is 1 exactly when direction bit n is 0, output bit n is 1 and pull_off_i is 0.
- R4: With pu_ovr_en_i[n] high, pad_pu_o[n] equals pu_ovr_val_i[n], whatever the registers and pull_off_i hold.
- R5: pad_oe_o[n] equals dir_ovr_val_i[n] when dir_ovr_en_i[n] is high, and direction bit n otherwise.
- R6: pad_out_o[n] is 0 while pad_oe_o[n] is 0. While it is 1, pad_out_o[n] equals val_ovr_val_i[n] if val_ovr_en_i[n] is high, and output bit n otherwise.
- R7: Input enable n equals ien_ovr_val_i[n] when ien_ovr_en_i[n] is high; otherwise it is the inverse of sleep_i. raw_in_o[n] is pad_in_i[n] AND input enable n, with no register on the path.
- R8: The pin level read with rd_sel_i = 2 is raw_in_o delayed by exactly two rising clock edges. A disabled input therefore reads 0 two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pull_off_i | input | 1 | Global pull-up kill, shared by all ports |
| sleep_i | input | 1 | Sleep state, disables digital inputs by default |
| dir_we_i | input | 1 | Direction register write strobe |
| out_we_i | input | 1 | Output register write strobe |
| wdata_i | input | W | Write data |
| rd_sel_i | input | 2 | Read selection |
| rdata_o | output | W | Read data |
| pu_ovr_en_i | input | W | Pull-up override enable per pin |
| pu_ovr_val_i | input | W | Pull-up override value per pin |
| dir_ovr_en_i | input | W | Driver-enable override enable per pin |
| dir_ovr_val_i | input | W | Driver-enable override value per pin |
| val_ovr_en_i | input | W | Driven-value override enable per pin |
| val_ovr_val_i | input | W | Driven-value override value per pin |
| ien_ovr_en_i | input | W | Input-enable override enable per pin |
| ien_ovr_val_i | input | W | Input-enable override value per pin |
| pad_in_i | input | W | Level seen at each pad |
| pad_oe_o | output | W | Pad output-driver enable |
| pad_out_o | output | W | Pad driven value |
| pad_pu_o | output | W | Pad pull-up enable |
| raw_in_o | output | W | Gated, unsynchronized input to the peripheral |

## Verification
Two things can happen in the same cycle: a CPU write to the output register and a peripheral taking over the driven value. The bench writes the output register in the very cycle the value override rises. It then checks that the pad shows the override value while the register reads back the new data, and that releasing the override exposes the written value. Sleep can also coincide with an input-enable override. The exhaustive sweep drives every combination of the thirteen per-pin and global controls, with eight different combinations on the eight pins at once, and judges each pad output and the two-edge read-back against equations computed in the bench.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    RD_DIR  = 2'd0,
    RD_OUT  = 2'd1,
    RD_PIN  = 2'd2,
    RD_NONE = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic en;
    logic val;
  } ovr_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr <= '0;
        else         sr <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr <= '0;
        else         sr <= {sr[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dir_we_i,
  input  logic         out_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_q_o,
  output logic [W-1:0] out_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q_o <= '0;
      out_q_o <= '0;
    end else begin
      if (dir_we_i) dir_q_o <= wdata_i;
      if (out_we_i) out_q_o <= wdata_i;
    end
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_mux_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_bit_i,
  input  logic out_bit_i,
  input  logic pull_off_i,
  input  logic sleep_i,
  input  ovr_t pu_ovr_i,
  input  ovr_t dir_ovr_i,
  input  ovr_t val_ovr_i,
  input  ovr_t ien_ovr_i,
  input  logic pad_in_i,
  output logic pad_oe_o,
  output logic pad_out_o,
  output logic pad_pu_o,
  output logic raw_in_o,
  output logic pin_sync_o
);
  logic pu_dflt, in_en, drv_val;

  assign pu_dflt   = ~dir_bit_i & out_bit_i & ~pull_off_i;
  assign pad_pu_o  = pu_ovr_i.en  ? pu_ovr_i.val  : pu_dflt;
  assign pad_oe_o  = dir_ovr_i.en ? dir_ovr_i.val : dir_bit_i;
  assign drv_val   = val_ovr_i.en ? val_ovr_i.val : out_bit_i;
  assign pad_out_o = pad_oe_o & drv_val;
  assign in_en     = ien_ovr_i.en ? ien_ovr_i.val : ~sleep_i;
  // gated input keeps a floating pad from reaching the peripheral or the read path
  assign raw_in_o  = pad_in_i & in_en;

  gpio_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in_o),
    .q_o   (pin_sync_o)
  );
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
  import gpio_mux_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pull_off_i,
  input  logic         sleep_i,
  input  logic         dir_we_i,
  input  logic         out_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [1:0]   rd_sel_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pu_ovr_en_i,
  input  logic [W-1:0] pu_ovr_val_i,
  input  logic [W-1:0] dir_ovr_en_i,
  input  logic [W-1:0] dir_ovr_val_i,
  input  logic [W-1:0] val_ovr_en_i,
  input  logic [W-1:0] val_ovr_val_i,
  input  logic [W-1:0] ien_ovr_en_i,
  input  logic [W-1:0] ien_ovr_val_i,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_pu_o,
  output logic [W-1:0] raw_in_o
);
  logic [W-1:0] dir_q, out_q, pin_q;
  rd_sel_e      rd_sel;

  gpio_port_regs #(.W(W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dir_we_i(dir_we_i),
    .out_we_i(out_we_i),
    .wdata_i (wdata_i),
    .dir_q_o (dir_q),
    .out_q_o (out_q)
  );

  for (genvar n = 0; n < W; n++) begin : g_pin
    gpio_pin_cell #(.STAGES(SYNC_STAGES)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dir_bit_i (dir_q[n]),
      .out_bit_i (out_q[n]),
      .pull_off_i(pull_off_i),
      .sleep_i   (sleep_i),
      .pu_ovr_i  ('{en: pu_ovr_en_i[n],  val: pu_ovr_val_i[n]}),
      .dir_ovr_i ('{en: dir_ovr_en_i[n], val: dir_ovr_val_i[n]}),
      .val_ovr_i ('{en: val_ovr_en_i[n], val: val_ovr_val_i[n]}),
      .ien_ovr_i ('{en: ien_ovr_en_i[n], val: ien_ovr_val_i[n]}),
      .pad_in_i  (pad_in_i[n]),
      .pad_oe_o  (pad_oe_o[n]),
      .pad_out_o (pad_out_o[n]),
      .pad_pu_o  (pad_pu_o[n]),
      .raw_in_o  (raw_in_o[n]),
      .pin_sync_o(pin_q[n])
    );
  end

  assign rd_sel = rd_sel_e'(rd_sel_i);

  always_comb begin
    unique case (rd_sel)
      RD_DIR:  rdata_o = dir_q;
      RD_OUT:  rdata_o = out_q;
      RD_PIN:  rdata_o = pin_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_mux_chk.sv
module gpio_port_mux_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         pull_off_i,
  input logic         sleep_i,
  input logic         dir_we_i,
  input logic         out_we_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] out_q,
  input logic [W-1:0] pin_q,
  input logic [W-1:0] pu_ovr_en_i,
  input logic [W-1:0] pu_ovr_val_i,
  input logic [W-1:0] dir_ovr_en_i,
  input logic [W-1:0] dir_ovr_val_i,
  input logic [W-1:0] val_ovr_en_i,
  input logic [W-1:0] val_ovr_val_i,
  input logic [W-1:0] ien_ovr_en_i,
  input logic [W-1:0] pad_oe_o,
  input logic [W-1:0] pad_out_o,
  input logic [W-1:0] pad_pu_o,
  input logic [W-1:0] raw_in_o
);
  logic [1:0] warm;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  p_dir_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> dir_q == $past(wdata_i));
  p_out_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_we_i |=> $stable(out_q));
  p_pu_dflt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_pu_o ^ (~dir_q & out_q & {W{~pull_off_i}})) & ~pu_ovr_en_i) == '0);
  p_pu_ovr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_pu_o ^ pu_ovr_val_i) & pu_ovr_en_i) == '0);
  p_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ dir_ovr_val_i) & dir_ovr_en_i) == '0
    && ((pad_oe_o ^ dir_q) & ~dir_ovr_en_i) == '0);
  p_out_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);
  p_out_ovr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ val_ovr_val_i) & val_ovr_en_i & pad_oe_o) == '0);
  p_sleep_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (raw_in_o & ~ien_ovr_en_i) == '0);
  p_sync_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2) |-> pin_q == $past(raw_in_o, 2));
endmodule

bind gpio_port_mux gpio_port_mux_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pull_off_i   (pull_off_i),
  .sleep_i      (sleep_i),
  .dir_we_i     (dir_we_i),
  .out_we_i     (out_we_i),
  .wdata_i      (wdata_i),
  .dir_q        (dir_q),
  .out_q        (out_q),
  .pin_q        (pin_q),
  .pu_ovr_en_i  (pu_ovr_en_i),
  .pu_ovr_val_i (pu_ovr_val_i),
  .dir_ovr_en_i (dir_ovr_en_i),
  .dir_ovr_val_i(dir_ovr_val_i),
  .val_ovr_en_i (val_ovr_en_i),
  .val_ovr_val_i(val_ovr_val_i),
  .ien_ovr_en_i (ien_ovr_en_i),
  .pad_oe_o     (pad_oe_o),
  .pad_out_o    (pad_out_o),
  .pad_pu_o     (pad_pu_o),
  .raw_in_o     (raw_in_o)
);

// File: tb/gpio_port_mux_tb.sv
`timescale 1ns/1ps
module gpio_port_mux_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pull_off, sleep, dir_we, out_we;
  logic [W-1:0] wdata;
  logic [1:0] rd_sel;
  logic [W-1:0] rdata;
  logic [W-1:0] pu_en, pu_val, dir_en, dir_val, val_en, val_val, ien_en, ien_val, pad_in;
  logic [W-1:0] pad_oe, pad_out, pad_pu, raw_in;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_port_mux #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pull_off_i(pull_off), .sleep_i(sleep),
    .dir_we_i(dir_we), .out_we_i(out_we), .wdata_i(wdata),
    .rd_sel_i(rd_sel), .rdata_o(rdata),
    .pu_ovr_en_i(pu_en), .pu_ovr_val_i(pu_val),
    .dir_ovr_en_i(dir_en), .dir_ovr_val_i(dir_val),
    .val_ovr_en_i(val_en), .val_ovr_val_i(val_val),
    .ien_ovr_en_i(ien_en), .ien_ovr_val_i(ien_val),
    .pad_in_i(pad_in), .pad_oe_o(pad_oe), .pad_out_o(pad_out),
    .pad_pu_o(pad_pu), .raw_in_o(raw_in)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [W-1:0] v);
    rd_sel = sel;
    #0.5;
    v = rdata;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] e_dir, e_out, e_oe, e_po, e_pu, e_raw;
    pull_off = 0; sleep = 0; dir_we = 0; out_we = 0; wdata = '0; rd_sel = 2'd0;
    pu_en = '0; pu_val = '0; dir_en = '0; dir_val = '0; val_en = '0; val_val = '0;
    ien_en = '0; ien_val = '0; pad_in = '1;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 oe", pad_oe, '0);
    chk("R1 pu", pad_pu, '0);
    rd(2'd0, v); chk("R1 dir", v, '0);
    rd(2'd1, v); chk("R1 out", v, '0);
    rd(2'd2, v); chk("R1 pin", v, '0);
    @(negedge clk); rst_ni = 1;

    // R2 unused read selection gives zeros
    @(negedge clk);
    dir_we = 1; out_we = 1; wdata = 8'h5A;
    @(negedge clk); dir_we = 0; out_we = 0;
    rd(2'd3, v); chk("R2 sel3", v, '0);
    rd(2'd0, v); chk("R2 dir both", v, 8'h5A);
    rd(2'd1, v); chk("R2 out both", v, 8'h5A);

    // R8 latency: exactly two edges
    pad_in = '0; repeat (3) @(negedge clk);
    pad_in = 8'hA5;
    @(negedge clk); rd(2'd2, v); chk("R8 one edge", v, 8'h00);
    @(negedge clk); rd(2'd2, v); chk("R8 two edges", v, 8'hA5);

    // R6 concurrent register write and value override
    dir_we = 1; out_we = 1; wdata = 8'hFF;
    @(negedge clk); dir_we = 0; wdata = 8'hF0;
    val_en = 8'hFF; val_val = 8'h0F;
    @(negedge clk); out_we = 0;
    chk("R6 ovr wins", pad_out, 8'h0F);
    rd(2'd1, v); chk("R2 out during ovr", v, 8'hF0);
    val_en = '0; #0.5;
    chk("R6 released", pad_out, 8'hF0);

    // R7 sleep coinciding with input override
    sleep = 1; ien_en = 8'h0F; ien_val = 8'h05; pad_in = 8'hFF; #0.5;
    chk("R7 sleep ovr", raw_in, 8'h05);
    @(negedge clk); @(negedge clk);
    rd(2'd2, v); chk("R8 sleep read", v, 8'h05);
    sleep = 0; ien_en = '0;

    // Exhaustive sweep: pin i takes control combination k*8+i
    for (int k = 0; k < 1024; k++) begin
      logic [W-1:0] wd, wo;
      for (int i = 0; i < W; i++) begin
        logic [12:0] c;
        c = 13'(k * 8 + i);
        wd[i] = c[0]; wo[i] = c[1];
        pu_en[i] = c[2]; pu_val[i] = c[3];
        dir_en[i] = c[4]; dir_val[i] = c[5];
        val_en[i] = c[6]; val_val[i] = c[7];
        ien_en[i] = c[8]; ien_val[i] = c[9];
        pad_in[i] = c[10];
        pull_off = c[11]; sleep = c[12];
      end
      for (int i = 0; i < W; i++) begin
        logic ien;
        e_pu[i]  = pu_en[i] ? pu_val[i] : (~wd[i] & wo[i] & ~pull_off);
        e_oe[i]  = dir_en[i] ? dir_val[i] : wd[i];
        e_po[i]  = e_oe[i] & (val_en[i] ? val_val[i] : wo[i]);
        ien      = ien_en[i] ? ien_val[i] : ~sleep;
        e_raw[i] = pad_in[i] & ien;
      end
      e_dir = wd; e_out = wo;
      wdata = wd; dir_we = 1;
      @(negedge clk); dir_we = 0; out_we = 1; wdata = wo;
      @(negedge clk); out_we = 0;
      chk("R3/R4 pull-up", pad_pu, e_pu);
      chk("R5 driver enable", pad_oe, e_oe);
      chk("R6 driven value", pad_out, e_po);
      chk("R7 raw input", raw_in, e_raw);
      rd(2'd0, v); chk("R2 dir read", v, e_dir);
      rd(2'd1, v); chk("R2 out read", v, e_out);
      rd(2'd2, v); chk("R8 pin read", v, e_raw);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule